// File: doc/BRIEF.md
# PLL Setting Search Engine

This block picks the control settings of a frequency synthesizer. The synthesizer output is the reference frequency times 2(m+1), divided by (d1+1) and by 2^d2. Here m is a 7-bit multiplier code, d1 is a 1-bit predivider code and d2 is a 2-bit post-divider code. The caller pulses a start strobe together with a reference frequency and a wanted frequency. The engine then evaluates one candidate setting per clock cycle. It returns the setting whose output comes closest to the wanted frequency without going above it.

Each candidate frequency is formed by one multiply and a right shift, so no general divider is needed. The search covers 1024 candidates. It ends early when a candidate hits the wanted frequency exactly. On completion the engine pulses a done strobe and presents four results: a packed control word, the frequency that the chosen setting achieves, an exact-hit flag and a flag for the case where no setting is low enough. These results stay valid until the next accepted start.

Top module: `pll_search_top`

## Requirements
- R1: The achieved frequency reported with a result equals floor(ref × 2(m+1) / ((d1+1) × 2^d2)) for the reported codes m, d1 and d2.
- R2: Candidates are visited with d1 descending from 1 to 0 in the outermost loop, d2 descending from 3 to 0 in the middle loop and m ascending from 0 to 127 in the innermost loop. The first candidate is m=0, d1=1, d2=3.
- R3: A candidate whose frequency is above the wanted frequency is never selected, so a reported achieved frequency never exceeds the wanted frequency.
- R4: A candidate exactly equal to the wanted frequency ends the search at once, with exact_hit=1. When that candidate is the k-th visited (k counting from 0), done rises k+1 cycles after the clock edge that accepts start.
- R5: When no candidate is exact, the engine reports the candidate with the smallest error (wanted minus achieved). Among candidates with equal error, the first one visited wins. Done then rises 1024 cycles after the accepting edge, with exact_hit=0.
- R6: The control word carries m in bits 22:16, d1 in bit 8 and d2 in bits 1:0, with every other bit zero.
- R7: When every candidate lies above the wanted frequency, the engine reports no_solution=1, a control word of zero and an achieved frequency of zero.
- R8: A start strobe that arrives while busy is high has no effect on the running search or on its result.
- R9: Done is high for exactly one cycle. Busy is high from the accepting edge until done rises. The results hold their values until the next accepted start.
- R10: After reset, done, busy, exact_hit and no_solution are 0, and the control word and achieved frequency are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begins a search when idle |
| ref_freq | input | FREQ_W | Reference frequency, captured at start |
| want_freq | input | FREQ_W | Wanted frequency, captured at start |
| busy | output | 1 | Search in progress |
| done | output | 1 | One-cycle pulse when the result is ready |
| ctrl_word | output | 32 | Packed m, d1 and d2 codes |
| got_freq | output | FREQ_W | Frequency achieved by the chosen codes |
| exact_hit | output | 1 | Achieved frequency equals the wanted frequency |
| no_solution | output | 1 | No candidate lies at or below the wanted frequency |

## Verification
On every cycle, the assertions check the following:
- done is a single-cycle pulse;
- a reported frequency never exceeds the captured wanted frequency;
- an exact hit reports exactly that frequency;
- the no-solution result is all zeros;
- the captured operands stay unchanged while a search runs;
- the candidate walker starts at its first setting.

Other behaviours can only be shown by the bench's sweeps over several reference frequencies and a range of wanted frequencies. These are the choice of the smallest-error candidate, the tie-breaking toward the earliest candidate, the exact-hit latency, which depends on the candidate's position in the visiting order, and the field layout of the control word.

// File: rtl/pll_search_pkg.sv
package pll_search_pkg;

    // Bit positions of the packed control word fields.
    localparam int CTRL_W     = 32;
    localparam int MUL_LSB    = 16;
    localparam int PREDIV_BIT = 8;
    localparam int POST_LSB   = 0;

    typedef enum logic [0:0] {
        S_IDLE = 1'b0,
        S_RUN  = 1'b1
    } search_state_e;

endpackage

// File: rtl/pll_cand_walker.sv
module pll_cand_walker #(
    parameter int M_W  = 7,
    parameter int D2_W = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic            step,
    output logic [M_W-1:0]  m_code,
    output logic            d1_code,
    output logic [D2_W-1:0] d2_code,
    output logic            last
);
    localparam logic [M_W-1:0]  M_MAX  = '1;
    localparam logic [D2_W-1:0] D2_MAX = '1;

    typedef struct packed {
        logic [M_W-1:0]  m;
        logic            d1;
        logic [D2_W-1:0] d2;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        if (load) begin
            w_d.m  = '0;
            w_d.d1 = 1'b1;
            w_d.d2 = D2_MAX;
        end else if (step) begin
            if (w_q.m != M_MAX) begin
                w_d.m = w_q.m + 1'b1;
            end else begin
                w_d.m = '0;
                if (w_q.d2 != '0) begin
                    w_d.d2 = w_q.d2 - 1'b1;
                end else begin
                    w_d.d2 = D2_MAX;
                    w_d.d1 = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) w_q <= '0;
        else        w_q <= w_d;
    end

    assign m_code  = w_q.m;
    assign d1_code = w_q.d1;
    assign d2_code = w_q.d2;
    assign last    = (w_q.m == M_MAX) && (w_q.d2 == '0) && !w_q.d1;

    // R2
    first_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (m_code == '0) && d1_code && (d2_code == D2_MAX));

endmodule

// File: rtl/pll_cand_eval.sv
module pll_cand_eval #(
    parameter int FREQ_W = 32,
    parameter int M_W    = 7,
    parameter int D2_W   = 2,
    localparam int PROD_W = FREQ_W + M_W + 2
) (
    input  logic [FREQ_W-1:0] ref_freq,
    input  logic [M_W-1:0]    m_code,
    input  logic              d1_code,
    input  logic [D2_W-1:0]   d2_code,
    output logic [PROD_W-1:0] cand_freq
);
    logic [M_W+1:0]    fb_factor;
    logic [PROD_W-1:0] product;
    logic [D2_W:0]     shift;

    always_comb begin
        fb_factor = {1'b0, ({1'b0, m_code} + 1'b1)} << 1;
        product   = PROD_W'(ref_freq) * PROD_W'(fb_factor);
        shift     = {1'b0, d2_code} + {{D2_W{1'b0}}, d1_code};
        cand_freq = product >> shift;
    end

endmodule

// File: rtl/pll_search_top.sv
module pll_search_top
    import pll_search_pkg::*;
#(
    parameter int FREQ_W = 32,
    parameter int M_W    = 7,
    parameter int D2_W   = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [FREQ_W-1:0] ref_freq,
    input  logic [FREQ_W-1:0] want_freq,
    output logic              busy,
    output logic              done,
    output logic [CTRL_W-1:0] ctrl_word,
    output logic [FREQ_W-1:0] got_freq,
    output logic              exact_hit,
    output logic              no_solution
);
    localparam int PROD_W = FREQ_W + M_W + 2;

    typedef struct packed {
        search_state_e     st;
        logic [FREQ_W-1:0] ref_f;
        logic [FREQ_W-1:0] want_f;
        logic              found;
        logic [FREQ_W-1:0] best_err;
        logic [M_W-1:0]    best_m;
        logic              best_d1;
        logic [D2_W-1:0]   best_d2;
        logic [FREQ_W-1:0] best_f;
        logic [CTRL_W-1:0] ctrl;
        logic [FREQ_W-1:0] got;
        logic              exact;
        logic              nosol;
        logic              done;
    } eng_t;

    eng_t r_d, r_q;

    logic              load, step, last;
    logic [M_W-1:0]    c_m;
    logic              c_d1;
    logic [D2_W-1:0]   c_d2;
    logic [PROD_W-1:0] c_freq;

    pll_cand_walker #(.M_W(M_W), .D2_W(D2_W)) u_walker (
        .clk(clk), .rst_n(rst_n), .load(load), .step(step),
        .m_code(c_m), .d1_code(c_d1), .d2_code(c_d2), .last(last)
    );

    pll_cand_eval #(.FREQ_W(FREQ_W), .M_W(M_W), .D2_W(D2_W)) u_eval (
        .ref_freq(r_q.ref_f), .m_code(c_m), .d1_code(c_d1), .d2_code(c_d2),
        .cand_freq(c_freq)
    );

    function automatic logic [CTRL_W-1:0] pack_ctrl(
        input logic [M_W-1:0] m, input logic d1, input logic [D2_W-1:0] d2);
        logic [CTRL_W-1:0] w;
        w = '0;
        w[MUL_LSB +: M_W]  = m;
        w[PREDIV_BIT]      = d1;
        w[POST_LSB +: D2_W] = d2;
        return w;
    endfunction

    logic              fits;
    logic [FREQ_W-1:0] err;

    always_comb begin
        r_d  = r_q;
        r_d.done = 1'b0;
        load = 1'b0;
        step = 1'b0;
        fits = c_freq <= PROD_W'(r_q.want_f);
        err  = r_q.want_f - c_freq[FREQ_W-1:0];
        unique case (r_q.st)
            S_IDLE: begin
                if (start) begin
                    load       = 1'b1;
                    r_d.st     = S_RUN;
                    r_d.ref_f  = ref_freq;
                    r_d.want_f = want_freq;
                    r_d.found  = 1'b0;
                    r_d.best_err = '1;
                end
            end
            S_RUN: begin
                if (fits && (err == '0)) begin
                    r_d.st    = S_IDLE;
                    r_d.done  = 1'b1;
                    r_d.exact = 1'b1;
                    r_d.nosol = 1'b0;
                    r_d.ctrl  = pack_ctrl(c_m, c_d1, c_d2);
                    r_d.got   = c_freq[FREQ_W-1:0];
                end else begin
                    if (fits && (!r_q.found || (err < r_q.best_err))) begin
                        r_d.found    = 1'b1;
                        r_d.best_err = err;
                        r_d.best_m   = c_m;
                        r_d.best_d1  = c_d1;
                        r_d.best_d2  = c_d2;
                        r_d.best_f   = c_freq[FREQ_W-1:0];
                    end
                    if (last) begin
                        r_d.st    = S_IDLE;
                        r_d.done  = 1'b1;
                        r_d.exact = 1'b0;
                        r_d.nosol = !r_d.found;
                        r_d.ctrl  = r_d.found ?
                            pack_ctrl(r_d.best_m, r_d.best_d1, r_d.best_d2) : '0;
                        r_d.got   = r_d.found ? r_d.best_f : '0;
                    end else begin
                        step = 1'b1;
                    end
                end
            end
            default: r_d.st = S_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign busy        = (r_q.st == S_RUN);
    assign done        = r_q.done;
    assign ctrl_word   = r_q.ctrl;
    assign got_freq    = r_q.got;
    assign exact_hit   = r_q.exact;
    assign no_solution = r_q.nosol;

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    // R3
    not_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (got_freq <= r_q.want_f));
    // R4
    exact_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && exact_hit) |-> (got_freq == r_q.want_f));
    // R7
    nosol_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && no_solution) |-> ((ctrl_word == '0) && (got_freq == '0)));
    // R8
    busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(r_q.want_f) && $stable(r_q.ref_f)));

endmodule

// File: tb/pll_search_top_tb.sv
module pll_search_top_tb;
    localparam int FREQ_W = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [FREQ_W-1:0] ref_freq = '0;
    logic [FREQ_W-1:0] want_freq = '0;
    logic busy, done, exact_hit, no_solution;
    logic [31:0] ctrl_word;
    logic [FREQ_W-1:0] got_freq;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    pll_search_top #(.FREQ_W(FREQ_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .ref_freq(ref_freq),
        .want_freq(want_freq), .busy(busy), .done(done), .ctrl_word(ctrl_word),
        .got_freq(got_freq), .exact_hit(exact_hit), .no_solution(no_solution)
    );

    task automatic chk(input string req, input longint act, input longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Reference search from the requirements (R1, R2, R3, R5).
    task automatic ref_search(input longint p, input longint t,
                              output longint e_ctrl, output longint e_freq,
                              output bit e_exact, output bit e_nosol,
                              output int e_lat);
        longint best_err;
        bit found;
        int pos;
        found = 0; best_err = 0; pos = 0;
        e_ctrl = 0; e_freq = 0; e_exact = 0; e_nosol = 0; e_lat = 1024;
        for (int d1 = 1; d1 >= 0; d1--) begin
            for (int d2 = 3; d2 >= 0; d2--) begin
                for (int m = 0; m <= 127; m++) begin
                    longint f;
                    f = (p * 2 * (m + 1)) / ((d1 + 1) * (1 << d2));
                    if (!e_exact && f <= t) begin
                        if (f == t) begin
                            e_exact = 1; e_lat = pos + 1;
                            e_ctrl = (longint'(m) << 16) | (longint'(d1) << 8) | d2;
                            e_freq = f;
                        end else if (!found || (t - f) < best_err) begin
                            found = 1; best_err = t - f;
                            e_ctrl = (longint'(m) << 16) | (longint'(d1) << 8) | d2;
                            e_freq = f;
                        end
                    end
                    pos++;
                end
            end
        end
        if (!e_exact && !found) e_nosol = 1;
    endtask

    task automatic run_one(input longint p, input longint t, input bit poke);
        longint e_ctrl, e_freq;
        bit e_exact, e_nosol;
        int e_lat, cnt;
        logic [31:0] held;
        ref_search(p, t, e_ctrl, e_freq, e_exact, e_nosol, e_lat);
        @(negedge clk);
        ref_freq = FREQ_W'(p); want_freq = FREQ_W'(t); start = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        cnt = 0;
        while (cnt < 2000) begin
            @(posedge clk);
            cnt++;
            @(negedge clk);
            if (poke && cnt == 5) begin
                // R8: a second start while busy must be ignored
                chk("R9 busy during search", busy, 1);
                ref_freq = FREQ_W'(p + 3); want_freq = FREQ_W'(t / 2 + 1);
                start = 1'b1;
            end else begin
                start = 1'b0;
            end
            if (done) break;
        end
        chk(poke ? "R8 latency with ignored start" : "R4 R5 latency", cnt, e_lat);
        chk("R6 ctrl word", ctrl_word, e_ctrl);
        chk("R1 R3 achieved freq", got_freq, e_freq);
        chk("R4 exact flag", exact_hit, e_exact);
        chk("R7 no solution flag", no_solution, e_nosol);
        held = ctrl_word;
        @(negedge clk);
        chk("R9 done one cycle", done, 0);
        chk("R9 busy clear", busy, 0);
        @(negedge clk);
        chk("R9 result held", ctrl_word, held);
    endtask

    initial begin
        longint plist [5] = '{1, 3, 10, 37, 1000};
        repeat (3) @(negedge clk);
        // R10
        chk("R10 done reset", done, 0);
        chk("R10 busy reset", busy, 0);
        chk("R10 ctrl reset", ctrl_word, 0);
        chk("R10 freq reset", got_freq, 0);
        chk("R10 flags reset", {exact_hit, no_solution}, 0);
        rst_n = 1'b1;
        // R2: first candidate exact (ref 16 -> 16*2/16 = 2)
        run_one(16, 2, 0);
        // R7: below the smallest candidate
        run_one(100, 5, 0);
        // R8
        run_one(37, 5000, 1);
        foreach (plist[k]) begin
            for (int i = 0; i < 20; i++) begin
                longint t;
                if (i == 19) t = plist[k] * 300;
                else t = (longint'(i) * i * plist[k] * 7) / 10 + i;
                run_one(plist[k], t, 0);
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule